// File: doc/BRIEF.md
# Frame CRC Scrubber

This block scrubs a small on-chip configuration store laid out as fixed-length frames. Each frame holds `DATA_WORDS` 16-bit data words followed by one 16-bit check word. The scanner reads one word per cycle and runs a CRC-16 over the data words of a frame. When it reaches the check word, it compares the running CRC against that stored value. A mismatch raises a sticky error flag and updates an error record. The scanner never stops: after the last frame it wraps to frame 0, marks the wrap with a one-cycle pulse and starts the next pass.

A write port loads the store. For self-test, an injection port lays a persistent XOR mask over chosen bits of one word. The mask can flip one bit, two arbitrary bits or two neighbouring bits. It stays in place until it is explicitly removed, so every later pass sees the corruption. A serial read port takes a snapshot of the error record together with the CRC most recently computed for frame 0, and shifts it out one bit per strobe while scanning goes on.

Top module: `crc_scrubber`

## Requirements
- R1: Each frame's CRC uses polynomial 0x1021, starts from 0xFFFF at the frame's first data word and absorbs every data word MSB first. Frame f occupies flat addresses f*(DATA_WORDS+1) through f*(DATA_WORDS+1)+DATA_WORDS, and the last of these holds the check word.
- R2: When a frame's computed CRC differs from its check word, `err_sticky` goes high. It stays high until `err_clr`.
- R3: Scanning runs continuously and checks every frame once per pass. A pass lasts NUM_FRAMES*(DATA_WORDS+1) cycles. `pass_done` is a one-cycle pulse raised after the last frame's result has been recorded.
- R4: `first_fail_frame` holds the index of the first failing frame seen since the last clear. Later failures leave it unchanged.
- R5: `fail_count` rises by one for each failing frame check and saturates at 2^CNT_W-1.
- R6: `err_clr` zeroes `err_sticky`, `first_fail_frame` and `fail_count`. If a failure is reported in the same cycle as the clear, the clear wins.
- R7: `inj_valid` ORs a flip pattern into the persistent XOR mask of word `inj_word` of frame `inj_frame`. The pattern depends on `inj_mode`: 0 flips nothing, 1 flips bit `inj_bit_a`, 2 flips bits `inj_bit_a` and `inj_bit_b`, and 3 flips `inj_bit_a` and `inj_bit_a`+1 (bits 15 and 14 when `inj_bit_a` is 15).
- R8: `inj_clr` removes every injected flip, and the stored contents read back unmodified.
- R9: The CRC computed for frame 0 is captured on every pass.
- R10: `sh_load` snapshots {err_sticky, first_fail_frame, fail_count, frame-0 CRC} with the MSB at `sh_out`. Each `sh_en` shifts the snapshot left and fills zeros. `sh_load` takes priority over `sh_en`.
- R11: Reset clears `err_sticky`, `fail_count`, `first_fail_frame`, `pass_done`, the shift register and the injection mask.
- R12: `wr_en` writes `wr_data` to flat address `wr_addr`, and the scanner sees the new word on its next visit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Store write strobe |
| wr_addr | input | $clog2(NUM_FRAMES*(DATA_WORDS+1)) (5) | Flat word address |
| wr_data | input | 16 | Word to store |
| inj_valid | input | 1 | Apply an injection pattern |
| inj_mode | input | 2 | 0 none, 1 single, 2 double, 3 adjacent pair |
| inj_frame | input | $clog2(NUM_FRAMES) (2) | Target frame |
| inj_word | input | $clog2(DATA_WORDS+1) (3) | Target word in frame (DATA_WORDS = check word) |
| inj_bit_a | input | 4 | First bit position |
| inj_bit_b | input | 4 | Second bit position (double mode) |
| inj_clr | input | 1 | Remove all injected flips |
| err_clr | input | 1 | Clear error record |
| sh_load | input | 1 | Snapshot record into shift register |
| sh_en | input | 1 | Shift snapshot one bit |
| err_sticky | output | 1 | Sticky mismatch flag |
| first_fail_frame | output | $clog2(NUM_FRAMES) (2) | First failing frame since clear |
| fail_count | output | CNT_W (4) | Saturating failure count |
| pass_done | output | 1 | One-cycle pass-complete pulse |
| sh_out | output | 1 | Serial snapshot output |

## Verification
The assertions assume a synchronous reset held for at least one clock edge, NUM_FRAMES of at least two and at least one data word per frame. They also assume that injection indices stay in range and that a double flip names two distinct bits. The stimulus keeps to these limits. It places every error clear, injection and snapshot load on the negative edge where `pass_done` is seen, so the action lands before any result of the new pass. Each verdict is read only after a full pass that runs entirely under the new mask and with a clean record. Store writes happen only during loading or between passes that are later discarded.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

    localparam int WORD_W        = 16;
    localparam int CRC_W         = 16;
    localparam int BIT_IDX_W     = 4;
    localparam int FRAME_FIELD_W = 8;
    localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
    localparam logic [CRC_W-1:0] CRC_SEED = 16'hFFFF;

    typedef enum logic [1:0] {
        FLIP_NONE = 2'd0,
        FLIP_ONE  = 2'd1,
        FLIP_TWO  = 2'd2,
        FLIP_PAIR = 2'd3
    } flip_mode_e;

    typedef struct packed {
        logic                     valid;
        logic                     last;
        logic                     fail;
        logic [FRAME_FIELD_W-1:0] frame;
        logic [CRC_W-1:0]         crc;
    } chk_result_t;

    // Advance the CRC by one full data word, most significant bit first.
    function automatic logic [CRC_W-1:0] crc_absorb_word(
        input logic [CRC_W-1:0]  crc_in,
        input logic [WORD_W-1:0] data
    );
        logic [CRC_W-1:0] c;
        logic             fb;
        c = crc_in;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            fb = c[CRC_W-1] ^ data[i];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

    // Bit pattern that one injection request ORs into the mask.
    function automatic logic [WORD_W-1:0] flip_pattern(
        input flip_mode_e           mode,
        input logic [BIT_IDX_W-1:0] a,
        input logic [BIT_IDX_W-1:0] b
    );
        logic [WORD_W-1:0] p;
        p = '0;
        case (mode)
            FLIP_ONE: p[a] = 1'b1;
            FLIP_TWO: begin
                p[a] = 1'b1;
                p[b] = 1'b1;
            end
            FLIP_PAIR: begin
                if (a == BIT_IDX_W'(WORD_W - 1)) begin
                    p[a]         = 1'b1;
                    p[a - 4'd1]  = 1'b1;
                end else begin
                    p[a]         = 1'b1;
                    p[a + 4'd1]  = 1'b1;
                end
            end
            default: p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/frame_store.sv
module frame_store
    import scrub_pkg::*;
#(
    parameter int NUM_FRAMES = 4,
    parameter int DATA_WORDS = 4,
    localparam int FRAME_LEN = DATA_WORDS + 1,
    localparam int DEPTH     = NUM_FRAMES * FRAME_LEN,
    localparam int ADDR_W    = $clog2(DEPTH),
    localparam int FRAME_W   = $clog2(NUM_FRAMES),
    localparam int WIDX_W    = $clog2(FRAME_LEN)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [WORD_W-1:0]    wr_data,
    input  logic                 inj_valid,
    input  flip_mode_e           inj_mode,
    input  logic [FRAME_W-1:0]   inj_frame,
    input  logic [WIDX_W-1:0]    inj_word,
    input  logic [BIT_IDX_W-1:0] inj_bit_a,
    input  logic [BIT_IDX_W-1:0] inj_bit_b,
    input  logic                 inj_clr,
    input  logic [FRAME_W-1:0]   rd_frame,
    input  logic [WIDX_W-1:0]    rd_word,
    output logic [WORD_W-1:0]    rd_data
);

    logic [WORD_W-1:0] mem_q  [DEPTH];
    logic [WORD_W-1:0] mask_q [DEPTH];

    int                inj_idx;
    int                rd_idx;
    logic              inj_in_range;
    logic [WORD_W-1:0] inj_pat;
    logic              mask_any;

    always_comb begin
        inj_idx      = int'(inj_frame) * FRAME_LEN + int'(inj_word);
        rd_idx       = int'(rd_frame) * FRAME_LEN + int'(rd_word);
        inj_in_range = (int'(inj_word) < FRAME_LEN) && (int'(inj_frame) < NUM_FRAMES);
        inj_pat      = flip_pattern(inj_mode, inj_bit_a, inj_bit_b);
    end

    always_ff @(posedge clk) begin
        if (wr_en && (int'(wr_addr) < DEPTH)) begin
            mem_q[int'(wr_addr)] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || inj_clr) begin
            for (int i = 0; i < DEPTH; i++) mask_q[i] <= '0;
        end else if (inj_valid && inj_in_range) begin
            mask_q[inj_idx] <= mask_q[inj_idx] | inj_pat;
        end
    end

    assign rd_data = mem_q[rd_idx] ^ mask_q[rd_idx];

    always_comb begin
        mask_any = 1'b0;
        for (int i = 0; i < DEPTH; i++) mask_any = mask_any | (|mask_q[i]);
    end

    // R8
    mask_wipe_chk: assert property (@(posedge clk) disable iff (rst)
        inj_clr |=> !mask_any);

    // R7
    no_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (!mask_any && !(inj_valid && inj_mode != FLIP_NONE)) |=> !mask_any);

endmodule

// File: rtl/frame_checker.sv
module frame_checker
    import scrub_pkg::*;
#(
    parameter int NUM_FRAMES = 4,
    parameter int DATA_WORDS = 4,
    localparam int FRAME_LEN = DATA_WORDS + 1,
    localparam int FRAME_W   = $clog2(NUM_FRAMES),
    localparam int WIDX_W    = $clog2(FRAME_LEN)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [WORD_W-1:0]  rd_data,
    output logic [FRAME_W-1:0] rd_frame,
    output logic [WIDX_W-1:0]  rd_word,
    output chk_result_t        res_o
);

    logic [FRAME_W-1:0] frame_q;
    logic [WIDX_W-1:0]  word_q;
    logic [CRC_W-1:0]   crc_q;
    chk_result_t        res_q;
    chk_result_t        res_d;

    logic               at_check;
    logic               at_last_frame;
    logic [CRC_W-1:0]   crc_base;
    logic [CRC_W-1:0]   crc_nx;

    always_comb begin
        at_check      = (word_q == WIDX_W'(DATA_WORDS));
        at_last_frame = (frame_q == FRAME_W'(NUM_FRAMES - 1));
        crc_base      = (word_q == '0) ? CRC_SEED : crc_q;
        crc_nx        = crc_absorb_word(crc_base, rd_data);
        res_d         = '0;
        if (at_check) begin
            res_d.valid = 1'b1;
            res_d.last  = at_last_frame;
            res_d.fail  = (crc_q != rd_data);
            res_d.frame = FRAME_FIELD_W'(frame_q);
            res_d.crc   = crc_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '0;
            word_q  <= '0;
            crc_q   <= CRC_SEED;
            res_q   <= '0;
        end else begin
            res_q <= res_d;
            if (at_check) begin
                word_q  <= '0;
                frame_q <= at_last_frame ? '0 : frame_q + 1'b1;
            end else begin
                word_q <= word_q + 1'b1;
                crc_q  <= crc_nx;
            end
        end
    end

    assign rd_frame = frame_q;
    assign rd_word  = word_q;
    assign res_o    = res_q;

    // R3
    result_gap_chk: assert property (@(posedge clk) disable iff (rst)
        res_q.valid |=> !res_q.valid);

    // R3
    word_range_chk: assert property (@(posedge clk) disable iff (rst)
        int'(word_q) <= DATA_WORDS);

endmodule

// File: rtl/error_log.sv
module error_log
    import scrub_pkg::*;
#(
    parameter int NUM_FRAMES = 4,
    parameter int CNT_W      = 4,
    localparam int FRAME_W   = $clog2(NUM_FRAMES),
    localparam int SH_W      = 1 + FRAME_W + CNT_W + CRC_W,
    localparam logic [CNT_W-1:0] CNT_MAX = '1
) (
    input  logic               clk,
    input  logic               rst,
    input  chk_result_t        res_i,
    input  logic               err_clr,
    input  logic               sh_load,
    input  logic               sh_en,
    output logic               err_o,
    output logic [FRAME_W-1:0] first_o,
    output logic [CNT_W-1:0]   count_o,
    output logic               pass_done_o,
    output logic               sh_out_o
);

    logic               err_q;
    logic [FRAME_W-1:0] first_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [CRC_W-1:0]   crc0_q;
    logic               pass_q;
    logic [SH_W-1:0]    sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q   <= 1'b0;
            first_q <= '0;
            cnt_q   <= '0;
            crc0_q  <= '0;
            pass_q  <= 1'b0;
            sh_q    <= '0;
        end else begin
            pass_q <= res_i.valid && res_i.last;
            if (res_i.valid && (res_i.frame == '0)) crc0_q <= res_i.crc;

            if (err_clr) begin
                err_q   <= 1'b0;
                first_q <= '0;
                cnt_q   <= '0;
            end else if (res_i.valid && res_i.fail) begin
                err_q <= 1'b1;
                if (!err_q) first_q <= FRAME_W'(res_i.frame);
                if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
            end

            if (sh_load)    sh_q <= {err_q, first_q, cnt_q, crc0_q};
            else if (sh_en) sh_q <= {sh_q[SH_W-2:0], 1'b0};
        end
    end

    assign err_o       = err_q;
    assign first_o     = first_q;
    assign count_o     = cnt_q;
    assign pass_done_o = pass_q;
    assign sh_out_o    = sh_q[SH_W-1];

    // R2
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (err_q && !err_clr) |=> err_q);

    // R4
    first_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (err_q && !err_clr) |=> $stable(first_q));

    // R5
    cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_MAX && !err_clr) |=> (cnt_q == CNT_MAX));

    // R6
    clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
        err_clr |=> (!err_q && cnt_q == '0));

    // R3
    pass_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        pass_q |=> !pass_q);

endmodule

// File: rtl/crc_scrubber.sv
module crc_scrubber
    import scrub_pkg::*;
#(
    parameter int NUM_FRAMES = 4,
    parameter int DATA_WORDS = 4,
    parameter int CNT_W      = 4,
    localparam int FRAME_LEN = DATA_WORDS + 1,
    localparam int DEPTH     = NUM_FRAMES * FRAME_LEN,
    localparam int ADDR_W    = $clog2(DEPTH),
    localparam int FRAME_W   = $clog2(NUM_FRAMES),
    localparam int WIDX_W    = $clog2(FRAME_LEN)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [WORD_W-1:0]    wr_data,
    input  logic                 inj_valid,
    input  logic [1:0]           inj_mode,
    input  logic [FRAME_W-1:0]   inj_frame,
    input  logic [WIDX_W-1:0]    inj_word,
    input  logic [BIT_IDX_W-1:0] inj_bit_a,
    input  logic [BIT_IDX_W-1:0] inj_bit_b,
    input  logic                 inj_clr,
    input  logic                 err_clr,
    input  logic                 sh_load,
    input  logic                 sh_en,
    output logic                 err_sticky,
    output logic [FRAME_W-1:0]   first_fail_frame,
    output logic [CNT_W-1:0]     fail_count,
    output logic                 pass_done,
    output logic                 sh_out
);

    logic [FRAME_W-1:0] scan_frame;
    logic [WIDX_W-1:0]  scan_word;
    logic [WORD_W-1:0]  scan_data;
    chk_result_t        chk_res;

    frame_store #(
        .NUM_FRAMES (NUM_FRAMES),
        .DATA_WORDS (DATA_WORDS)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .inj_valid (inj_valid),
        .inj_mode  (flip_mode_e'(inj_mode)),
        .inj_frame (inj_frame),
        .inj_word  (inj_word),
        .inj_bit_a (inj_bit_a),
        .inj_bit_b (inj_bit_b),
        .inj_clr   (inj_clr),
        .rd_frame  (scan_frame),
        .rd_word   (scan_word),
        .rd_data   (scan_data)
    );

    frame_checker #(
        .NUM_FRAMES (NUM_FRAMES),
        .DATA_WORDS (DATA_WORDS)
    ) u_check (
        .clk      (clk),
        .rst      (rst),
        .rd_data  (scan_data),
        .rd_frame (scan_frame),
        .rd_word  (scan_word),
        .res_o    (chk_res)
    );

    error_log #(
        .NUM_FRAMES (NUM_FRAMES),
        .CNT_W      (CNT_W)
    ) u_log (
        .clk         (clk),
        .rst         (rst),
        .res_i       (chk_res),
        .err_clr     (err_clr),
        .sh_load     (sh_load),
        .sh_en       (sh_en),
        .err_o       (err_sticky),
        .first_o     (first_fail_frame),
        .count_o     (fail_count),
        .pass_done_o (pass_done),
        .sh_out_o    (sh_out)
    );

    // R2
    detect_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (chk_res.valid && chk_res.fail && !err_clr) |=> err_sticky);

    // R3
    pass_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        (chk_res.valid && chk_res.last) |=> pass_done);

endmodule

// File: tb/crc_scrubber_tb.sv
module crc_scrubber_tb;

    localparam int NF   = 4;
    localparam int DW   = 4;
    localparam int FL   = DW + 1;
    localparam int CW   = 4;
    localparam int SH_W = 1 + 2 + CW + 16;

    // fields: [17:16] mode [15:14] frame [13:11] word [10:7] bit a [6:3] bit b [2] expect error [1:0] expect first
    localparam logic [17:0] VEC [7] = '{
        {2'd0, 2'd1, 3'd2, 4'd3,  4'd0, 1'b0, 2'd0},
        {2'd1, 2'd2, 3'd1, 4'd5,  4'd0, 1'b1, 2'd2},
        {2'd2, 2'd1, 3'd0, 4'd0,  4'd15, 1'b1, 2'd1},
        {2'd3, 2'd3, 3'd3, 4'd7,  4'd0, 1'b1, 2'd3},
        {2'd3, 2'd0, 3'd2, 4'd15, 4'd0, 1'b1, 2'd0},
        {2'd1, 2'd1, 3'd4, 4'd3,  4'd0, 1'b1, 2'd1},
        {2'd2, 2'd3, 3'd2, 4'd4,  4'd9, 1'b1, 2'd3}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [4:0]  wr_addr;
    logic [15:0] wr_data;
    logic        inj_valid;
    logic [1:0]  inj_mode;
    logic [1:0]  inj_frame;
    logic [2:0]  inj_word;
    logic [3:0]  inj_bit_a;
    logic [3:0]  inj_bit_b;
    logic        inj_clr;
    logic        err_clr;
    logic        sh_load;
    logic        sh_en;
    logic        err_sticky;
    logic [1:0]  first_fail_frame;
    logic [3:0]  fail_count;
    logic        pass_done;
    logic        sh_out;

    int checks = 0;
    int errs   = 0;
    logic [15:0] model [NF*FL];

    always #2 clk = ~clk;

    crc_scrubber #(.NUM_FRAMES(NF), .DATA_WORDS(DW), .CNT_W(CW)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .inj_valid(inj_valid), .inj_mode(inj_mode), .inj_frame(inj_frame),
        .inj_word(inj_word), .inj_bit_a(inj_bit_a), .inj_bit_b(inj_bit_b),
        .inj_clr(inj_clr), .err_clr(err_clr), .sh_load(sh_load), .sh_en(sh_en),
        .err_sticky(err_sticky), .first_fail_frame(first_fail_frame),
        .fail_count(fail_count), .pass_done(pass_done), .sh_out(sh_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Bit-serial reference CRC over the data words of one frame in the model.
    function automatic logic [15:0] ref_crc(input int f);
        logic [15:0] r = 16'hFFFF;
        for (int w = 0; w < DW; w++) begin
            for (int b = 15; b >= 0; b--) begin
                logic top = r[15] ^ model[f*FL + w][b];
                r = r << 1;
                if (top) r = r ^ 16'h1021;
            end
        end
        return r;
    endfunction

    task automatic put(input int addr, input logic [15:0] d);
        model[addr] = d;
        wr_addr = 5'(addr);
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_pass();
        do @(negedge clk); while (!pass_done);
    endtask

    task automatic clear_err();
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    task automatic clear_inj();
        inj_clr = 1'b1;
        @(negedge clk);
        inj_clr = 1'b0;
    endtask

    task automatic inject(input logic [1:0] m, input logic [1:0] f, input logic [2:0] w,
                          input logic [3:0] a, input logic [3:0] b);
        inj_mode = m; inj_frame = f; inj_word = w; inj_bit_a = a; inj_bit_b = b;
        inj_valid = 1'b1;
        @(negedge clk);
        inj_valid = 1'b0;
    endtask

    // Wait for a full pass under the current mask with a clean record.
    task automatic fresh_pass();
        wait_pass();
        clear_err();
        wait_pass();
    endtask

    task automatic shift_out(output logic [SH_W-1:0] v);
        sh_load = 1'b1;
        @(negedge clk);
        sh_load = 1'b0;
        v = '0;
        for (int i = 0; i < SH_W; i++) begin
            v = {v[SH_W-2:0], sh_out};
            sh_en = 1'b1;
            @(negedge clk);
            sh_en = 1'b0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [SH_W-1:0] snap;
        logic [15:0] crc0;
        int n;
        rst = 1'b1; wr_en = 0; wr_addr = 0; wr_data = 0; inj_valid = 0; inj_mode = 0;
        inj_frame = 0; inj_word = 0; inj_bit_a = 0; inj_bit_b = 0; inj_clr = 0;
        err_clr = 0; sh_load = 0; sh_en = 0;
        repeat (4) @(negedge clk);
        // R11 reset state
        chk("R11 err_sticky", 32'(err_sticky), 0);
        chk("R11 fail_count", 32'(fail_count), 0);
        chk("R11 pass_done", 32'(pass_done), 0);
        chk("R11 sh_out", 32'(sh_out), 0);
        rst = 1'b0;

        // R12 load every frame with data and a matching check word
        for (int f = 0; f < NF; f++) begin
            for (int w = 0; w < DW; w++)
                put(f*FL + w, 16'hA5C3 ^ 16'(f * 16'h1357) ^ 16'(w * 16'h0F21));
            put(f*FL + DW, ref_crc(f));
        end
        crc0 = ref_crc(0);

        // R1 clean store passes
        fresh_pass();
        chk("R1 clean err", 32'(err_sticky), 0);
        chk("R1 clean count", 32'(fail_count), 0);

        // R3 pass length
        n = 0;
        do begin @(negedge clk); n++; end while (!pass_done);
        chk("R3 pass length", n, NF*FL);

        // R9 R10 snapshot of clean record
        shift_out(snap);
        chk("R10 R9 clean snapshot", 32'(snap), {9'd0, 1'b0, 2'd0, 4'd0, crc0});
        chk("R10 zero fill", 32'(sh_out), 0);

        // R12 R2 corrupted check word of frame 3
        put(3*FL + DW, model[3*FL + DW] ^ 16'h0001);
        fresh_pass();
        chk("R2 bad check word err", 32'(err_sticky), 1);
        chk("R4 bad check word first", 32'(first_fail_frame), 3);
        chk("R5 bad check word count", 32'(fail_count), 1);
        wait_pass();
        chk("R3 keeps scanning count", 32'(fail_count), 2);
        chk("R2 still set", 32'(err_sticky), 1);
        put(3*FL + DW, ref_crc(3));
        fresh_pass();
        chk("R12 restored err", 32'(err_sticky), 0);

        // R7 vector table of injections
        foreach (VEC[k]) begin
            wait_pass();
            clear_inj();
            inject(VEC[k][17:16], VEC[k][15:14], VEC[k][13:11], VEC[k][10:7], VEC[k][6:3]);
            fresh_pass();
            chk($sformatf("R7 vec%0d err", k), 32'(err_sticky), 32'(VEC[k][2]));
            chk($sformatf("R4 vec%0d first", k), 32'(first_fail_frame), 32'(VEC[k][1:0]));
            chk($sformatf("R5 vec%0d count", k), 32'(fail_count), 32'(VEC[k][2]));
        end

        // R8 removing injections restores clean results
        wait_pass();
        clear_inj();
        fresh_pass();
        chk("R8 after inj_clr", 32'(err_sticky), 0);

        // R5 saturation with every frame failing, R4 first is frame 0
        for (int f = 0; f < NF; f++) inject(2'd1, 2'(f), 3'd0, 4'd2, 4'd0);
        fresh_pass();
        repeat (3) wait_pass();
        chk("R5 saturated", 32'(fail_count), 15);
        chk("R4 first of many", 32'(first_fail_frame), 0);
        wait_pass();
        chk("R5 stays saturated", 32'(fail_count), 15);

        // R6 clear while frames keep failing
        clear_err();
        chk("R6 clear err", 32'(err_sticky), 0);
        chk("R6 clear count", 32'(fail_count), 0);

        // R10 snapshot of an error record, frame 0 clean so R9 value holds
        wait_pass();
        clear_inj();
        inject(2'd1, 2'd2, 3'd1, 4'd11, 4'd0);
        fresh_pass();
        shift_out(snap);
        chk("R10 error snapshot", 32'(snap), {9'd0, 1'b1, 2'd2, 4'd1, crc0});

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule